// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits at the front of the execute stage of a five-stage in-order pipeline. It decides, for each of the two ALU operands, whether the value read from the register file during decode is still current. If it is not, the block substitutes a newer result that is still travelling down the pipeline. Two producers are considered: the instruction one stage ahead, whose ALU result sits in the memory-stage register, and the instruction two stages ahead, whose final value sits in the write-back register.

The block is purely combinational. For each operand it compares the source register number against each producer's destination number. A producer can match only if its write flag is set and its destination is not register zero. The block then emits a 2-bit select code, and the operand mux steers the chosen value to its output in the same cycle. When both producers target the same register, the younger one (memory stage) wins, because it carries the later architectural value. Stall detection for loads and store-data forwarding are handled elsewhere.

Top module: `opnd_bypass_unit`

## Requirements
- R1: When the memory-stage producer has its write flag set, a nonzero destination, and a destination equal to an operand's source register, that operand's select is 2'b10 and the operand output equals the memory-stage result.
- R2: When the write-back producer has its write flag set, a nonzero destination equal to an operand's source register, and the memory-stage producer does not match, the select is 2'b01 and the operand equals the write-back value.
- R3: Operand A is decided only from the first source register (rs) and operand B only from the second (rt). The two decisions are independent, so both operands may be bypassed in the same cycle, from the same producer or from different ones.
- R4: When both producers match the same source register, the memory-stage producer takes priority (select 2'b10). This covers a run of three back-to-back writes to one register.
- R5: A producer whose destination is register 0 never causes a bypass, even when the source register is also 0 and the write flag is set.
- R6: A producer whose write flag is clear never causes a bypass, whatever its destination.
- R7: When no producer qualifies, the select is 2'b00 and the operand equals the register-file value carried from decode.
- R8: The select outputs never take the value 2'b11. The operand mux treats 2'b11 as 2'b00.
- R9: Outputs depend only on present inputs. A change of inputs is reflected in the selects and operands within the same cycle, with no state carried between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | 5 | First source register number of the instruction in execute |
| ex_rt_i | input | 5 | Second source register number of the instruction in execute |
| ex_rs_data_i | input | 32 | Register-file value read for the first source |
| ex_rt_data_i | input | 32 | Register-file value read for the second source |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes a register |
| mem_dst_i | input | 5 | Memory-stage destination register number |
| mem_result_i | input | 32 | Memory-stage ALU result |
| wb_wr_en_i | input | 1 | Write-back instruction writes a register |
| wb_dst_i | input | 5 | Write-back destination register number |
| wb_result_i | input | 32 | Write-back value |
| sel_a_o | output | 2 | Select code for operand A (00 regfile, 01 write-back, 10 memory stage) |
| sel_b_o | output | 2 | Select code for operand B |
| opnd_a_o | output | 32 | Selected operand A |
| opnd_b_o | output | 32 | Selected operand B |

## Verification
The bench targets the conflict where both producers name the same register, including three successive writes to one register. A design without priority would pass the older write-back value and compute with stale data. Register-zero destinations are driven with matching zero sources and the write flag set; a design that skipped the zero test would bypass a value into a hardwired-zero read. Cases with the write flag clear and a matching destination catch a design that forwards from non-writing instructions. Mixed cases, with A bypassed from one stage and B from the other or with rs equal to rt, expose any crosswiring between the two operand paths.

// File: rtl/opnd_bypass_pkg.sv
// Package: shared select encoding for the operand bypass unit.
// Assumes: the code values are fixed because the execute stage decodes them.
package opnd_bypass_pkg;

    typedef enum logic [1:0] {
        BYP_REGFILE = 2'b00,
        BYP_WB      = 2'b01,
        BYP_MEM     = 2'b10,
        BYP_RSVD    = 2'b11
    } byp_sel_t;

endpackage : opnd_bypass_pkg

// File: rtl/byp_producer_match.sv
// Module: byp_producer_match
// Decides whether one in-flight producer supplies the value of one source
// register. Assumes register 0 is hardwired to zero and is never a real
// destination for bypass purposes.
module byp_producer_match #(
    parameter int REG_AW = 5
) (
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] dst_i,
    input  logic [REG_AW-1:0] src_i,
    output logic              hit_o
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Qualify the producer: must write, must not target r0, must match.
    always_comb begin
        hit_o = wr_en_i && (dst_i != ZERO_REG) && (dst_i == src_i);
    end

endmodule : byp_producer_match

// File: rtl/byp_sel_ctrl.sv
// Module: byp_sel_ctrl
// Turns the two producer hit flags of one operand into a select code,
// giving the memory-stage producer priority. Assumes hits are already
// qualified by write flag and nonzero destination.
module byp_sel_ctrl
    import opnd_bypass_pkg::*;
(
    input  logic     mem_hit_i,
    input  logic     wb_hit_i,
    output byp_sel_t sel_o
);

    // Priority encode: younger producer first, then older, else regfile.
    always_comb begin
        if (mem_hit_i) begin
            sel_o = BYP_MEM;
        end else if (wb_hit_i) begin
            sel_o = BYP_WB;
        end else begin
            sel_o = BYP_REGFILE;
        end
    end

    // Guard the encoder outputs against its inputs.
    always_comb begin
        AST_SEL_NOT_RSVD: assert (sel_o != BYP_RSVD);                         // R8
        AST_WB_YIELDS: assert (!(mem_hit_i && wb_hit_i) || sel_o == BYP_MEM); // R4
    end

endmodule : byp_sel_ctrl

// File: rtl/byp_operand_mux.sv
// Module: byp_operand_mux
// Steers one ALU operand from the register file, the write-back value or the
// memory-stage result. Assumes the reserved code must fall back to regfile.
module byp_operand_mux
    import opnd_bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  byp_sel_t          sel_i,
    input  logic [DATA_W-1:0] rf_data_i,
    input  logic [DATA_W-1:0] wb_data_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [DATA_W-1:0] opnd_o
);

    // Select the operand source; reserved code behaves as regfile.
    always_comb begin
        unique case (sel_i)
            BYP_MEM:     opnd_o = mem_data_i;
            BYP_WB:      opnd_o = wb_data_i;
            BYP_REGFILE: opnd_o = rf_data_i;
            default:     opnd_o = rf_data_i;
        endcase
    end

    // The reserved code must never let a pipeline value through.
    always_comb begin
        AST_RSVD_AS_RF: assert (sel_i != BYP_RSVD || opnd_o == rf_data_i); // R8
    end

endmodule : byp_operand_mux

// File: rtl/opnd_bypass_unit.sv
// Module: opnd_bypass_unit (top)
// Bypass selection for both ALU operands of the execute stage. Each operand
// lane compares its source register with the memory-stage and write-back
// destinations and muxes in the newest value. Purely combinational; assumes
// the caller registers the outputs if timing requires it.
module opnd_bypass_unit
    import opnd_bypass_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] ex_rs_i,
    input  logic [REG_AW-1:0] ex_rt_i,
    input  logic [DATA_W-1:0] ex_rs_data_i,
    input  logic [DATA_W-1:0] ex_rt_data_i,
    input  logic              mem_wr_en_i,
    input  logic [REG_AW-1:0] mem_dst_i,
    input  logic [DATA_W-1:0] mem_result_i,
    input  logic              wb_wr_en_i,
    input  logic [REG_AW-1:0] wb_dst_i,
    input  logic [DATA_W-1:0] wb_result_i,
    output logic [1:0]        sel_a_o,
    output logic [1:0]        sel_b_o,
    output logic [DATA_W-1:0] opnd_a_o,
    output logic [DATA_W-1:0] opnd_b_o
);

    localparam int NUM_OPS = 2;
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [REG_AW-1:0] lane_src  [NUM_OPS];
    logic [DATA_W-1:0] lane_rf   [NUM_OPS];
    byp_sel_t          lane_sel  [NUM_OPS];
    logic [DATA_W-1:0] lane_opnd [NUM_OPS];

    // Gather per-lane inputs: lane 0 is operand A (rs), lane 1 is B (rt).
    always_comb begin
        lane_src[0] = ex_rs_i;
        lane_src[1] = ex_rt_i;
        lane_rf[0]  = ex_rs_data_i;
        lane_rf[1]  = ex_rt_data_i;
    end

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_lane
        logic mem_hit;
        logic wb_hit;

        byp_producer_match #(.REG_AW(REG_AW)) i_mem_match (
            .wr_en_i (mem_wr_en_i),
            .dst_i   (mem_dst_i),
            .src_i   (lane_src[op]),
            .hit_o   (mem_hit)
        );

        byp_producer_match #(.REG_AW(REG_AW)) i_wb_match (
            .wr_en_i (wb_wr_en_i),
            .dst_i   (wb_dst_i),
            .src_i   (lane_src[op]),
            .hit_o   (wb_hit)
        );

        byp_sel_ctrl i_sel_ctrl (
            .mem_hit_i (mem_hit),
            .wb_hit_i  (wb_hit),
            .sel_o     (lane_sel[op])
        );

        byp_operand_mux #(.DATA_W(DATA_W)) i_mux (
            .sel_i      (lane_sel[op]),
            .rf_data_i  (lane_rf[op]),
            .wb_data_i  (wb_result_i),
            .mem_data_i (mem_result_i),
            .opnd_o     (lane_opnd[op])
        );
    end : g_lane

    // Drive the ports from the lanes.
    always_comb begin
        sel_a_o  = lane_sel[0];
        sel_b_o  = lane_sel[1];
        opnd_a_o = lane_opnd[0];
        opnd_b_o = lane_opnd[1];
    end

    // Port-level checks relating producers to the chosen selects.
    always_comb begin
        AST_ZERO_NO_MEM_A: assert (mem_dst_i != ZERO_REG || sel_a_o != 2'b10); // R5
        AST_ZERO_NO_WB_B: assert (wb_dst_i != ZERO_REG || sel_b_o != 2'b01);   // R5
        AST_IDLE_MEM_B: assert (mem_wr_en_i || sel_b_o != 2'b10);              // R6
        AST_IDLE_WB_A: assert (wb_wr_en_i || sel_a_o != 2'b01);                // R6
        AST_MEM_A_SRC: assert (sel_a_o != 2'b10 || mem_dst_i == ex_rs_i);      // R3
        AST_WB_B_SRC: assert (sel_b_o != 2'b01 || wb_dst_i == ex_rt_i);        // R3
    end

endmodule : opnd_bypass_unit

// File: tb/test_opnd_bypass_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies a stimulus on the falling edge and
// queues the expected outputs; the monitor compares on the next rising edge.
module test_opnd_bypass_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [4:0]  rs, rt, md, wd;
    logic [31:0] rfa, rfb, mr, wr;
    logic        mw, ww;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] op_a, op_b;

    opnd_bypass_unit i_opnd_bypass_unit (
        .ex_rs_i(rs), .ex_rt_i(rt), .ex_rs_data_i(rfa), .ex_rt_data_i(rfb),
        .mem_wr_en_i(mw), .mem_dst_i(md), .mem_result_i(mr),
        .wb_wr_en_i(ww), .wb_dst_i(wd), .wb_result_i(wr),
        .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(op_a), .opnd_b_o(op_b)
    );

    typedef struct {
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic [31:0] oa;
        logic [31:0] ob;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Expected select per requirements R1, R2, R4, R5, R6, R7.
    function automatic logic [1:0] want_sel(input logic [4:0] src);
        if (mw && md != 5'd0 && md == src) return 2'b10;
        if (ww && wd != 5'd0 && wd == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] want_val(input logic [1:0] s, input logic [31:0] rf);
        return (s == 2'b10) ? mr : (s == 2'b01) ? wr : rf;
    endfunction

    task automatic apply(input logic [4:0] a_rs, input logic [4:0] a_rt,
                         input logic a_mw, input logic [4:0] a_md,
                         input logic a_ww, input logic [4:0] a_wd,
                         input string tag);
        exp_t e;
        @(negedge clk);
        rs = a_rs; rt = a_rt; mw = a_mw; md = a_md; ww = a_ww; wd = a_wd;
        rfa = 32'hA000_0000 | {27'd0, a_rs};
        rfb = 32'hB000_0000 | {27'd0, a_rt};
        mr  = 32'h3E30_0000 | {27'd0, a_md};
        wr  = 32'h7B70_0000 | {27'd0, a_wd};
        e.sa = want_sel(a_rs);
        e.sb = want_sel(a_rt);
        e.oa = want_val(e.sa, rfa);
        e.ob = want_val(e.sb, rfb);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Monitor: compare the outputs half a cycle after each stimulus.
    always @(posedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp(e.tag, "sel_a", {30'd0, sel_a}, {30'd0, e.sa});
            cmp(e.tag, "sel_b", {30'd0, sel_b}, {30'd0, e.sb});
            cmp(e.tag, "opnd_a", op_a, e.oa);
            cmp(e.tag, "opnd_b", op_b, e.ob);
            cmp(e.tag, "no_code_11", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
        end
    end

    initial begin
        rs = '0; rt = '0; md = '0; wd = '0; mw = 1'b0; ww = 1'b0;
        rfa = '0; rfb = '0; mr = '0; wr = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R7: idle state, nothing writes
        apply(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, "R7_idle");
        apply(5'd3, 5'd4, 1'b1, 5'd9, 1'b1, 5'd10, "R7_nomatch");
        // R1: memory-stage bypass on A, then on B
        apply(5'd1, 5'd5, 1'b1, 5'd1, 1'b0, 5'd0, "R1_a");
        apply(5'd7, 5'd1, 1'b1, 5'd1, 1'b0, 5'd0, "R1_b");
        // R2: write-back bypass on A, then on B
        apply(5'd6, 5'd2, 1'b0, 5'd6, 1'b1, 5'd6, "R2_a");
        apply(5'd8, 5'd12, 1'b1, 5'd3, 1'b1, 5'd12, "R2_b");
        // R3: A from memory stage, B from write-back; and rs equal rt
        apply(5'd4, 5'd5, 1'b1, 5'd4, 1'b1, 5'd5, "R3_split");
        apply(5'd5, 5'd4, 1'b1, 5'd4, 1'b1, 5'd5, "R3_swap");
        apply(5'd9, 5'd9, 1'b1, 5'd9, 1'b0, 5'd0, "R3_same");
        // R4: both producers match; three writes to r1 in a row
        apply(5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1, "R4_triple_r1");
        apply(5'd31, 5'd2, 1'b1, 5'd31, 1'b1, 5'd31, "R4_conflict_a");
        // R5: register zero never bypassed
        apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, "R5_r0_both");
        apply(5'd0, 5'd3, 1'b1, 5'd0, 1'b1, 5'd3, "R5_r0_mem");
        apply(5'd2, 5'd2, 1'b1, 5'd0, 1'b1, 5'd2, "R5_fallthrough");
        // R6: write flag clear blocks bypass
        apply(5'd11, 5'd11, 1'b0, 5'd11, 1'b0, 5'd11, "R6_nowrite");
        apply(5'd11, 5'd13, 1'b0, 5'd11, 1'b1, 5'd11, "R6_mem_idle");
        // R9: rapid changes of input patterns, small register range
        for (int k = 0; k < 300; k++) begin
            apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)), "R9_sweep");
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule : test_opnd_bypass_unit